// File: doc/BRIEF.md
# Interrupt acceptance and autovector sequencer

This block is the processor-side front end of interrupt entry. A three-bit priority level arrives on `ipl_i`. The block filters it, then compares it against the current interrupt mask. When it accepts a request, it walks through a fixed series of bus transactions:

- an acknowledge read whose address is chosen by the level;
- three word writes that stack the program counter and status word;
- two word reads that fetch the 32-bit handler address into the program counter.

The vector number is the low byte returned by the acknowledge read. It is scaled by four and added to a loadable vector base.

The block owns the architectural state that interrupt entry touches: program counter, system stack pointer, interrupt mask, supervisor flag and vector base. It talks to memory through one request/acknowledge port, one transaction at a time. Instruction execution and the rest of the exception model sit outside it.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset the mask is 0, supervisor mode is off, the stack pointer equals `SP_RESET`, the program counter equals `PC_RESET`, the vector base is 0, and neither `mem_req_o` nor `busy_o` is asserted.
- R2: A value on `ipl_i` is acted on only after it has been seen on two consecutive clock edges. A level present for a single cycle never starts a sequence; a level held for two cycles does.
- R3: Level 0 is never accepted. Levels 1 to 6 are accepted only while strictly greater than the current mask.
- R4: Level 7 is accepted whenever the filtered level enters 7, regardless of mask. While it stays at 7 it is not accepted again. Leaving 7 and returning to it produces a new acceptance.
- R5: The first transaction of a sequence is a read at address 0xFFFFF0 OR (level << 1), e.g. 0xFFFFF6 for level 3.
- R6: The vector address is (vector base + (bits 7:0 of the acknowledge read data) × 4), truncated to 24 bits. Autovector bytes 0x19 to 0x1F give offsets 0x064 to 0x07C. Pulsing `vbr_load_i` loads `vbr_val_i` into the vector base.
- R7: Stacking is three word writes in this order: PC bits 15:0 at SP−2, PC bits 31:16 at SP−4, then the status word at SP−6. The status word holds the pre-acceptance supervisor flag in bit 13 and the pre-acceptance mask in bits 10:8, with all other bits 0. SP ends 6 lower, dropping by 2 per completed write.
- R8: `super_o` is set in the same cycle `busy_o` rises. The mask becomes the accepted level when the status-word write completes, and the mask never decreases outside reset.
- R9: The handler address is read as the high word at the vector address and the low word at vector address + 2. Both are loaded into the program counter, after which `busy_o` falls.
- R10: A request keeps its address, write flag and data stable until it is acknowledged. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ipl_i | input | 3 | Requested priority level, 0 = none |
| vbr_load_i | input | 1 | Load strobe for the vector base |
| vbr_val_i | input | 32 | New vector base value |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = word write, 0 = word read |
| mem_addr_o | output | 24 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Transaction complete this cycle |
| mem_rdata_i | input | 16 | Read data, valid with `mem_ack_i` |
| pc_o | output | 32 | Program counter |
| sp_o | output | 32 | System stack pointer |
| mask_o | output | 3 | Current interrupt mask |
| super_o | output | 1 | Supervisor mode flag |
| busy_o | output | 1 | A sequence is in progress |

## Verification
Levels below, equal to and above the current mask separate the strict comparison from an inclusive one. Single-cycle and two-cycle pulses bound the stability filter from both sides. Level 7 is tested held, re-entered, and arriving with the mask already at 7; this separates edge-triggered non-maskable acceptance from level-triggered behaviour. Autovector bytes and arbitrary bytes, with a zero and a nonzero vector base, cover the scaling and the offset. Random acknowledge latency stresses request stability, and random resets interleave a random level sequence.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IACK,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_SR,
        ST_VEC_HI,
        ST_VEC_LO
    } seq_state_e;

    // Snapshot taken at acceptance
    typedef struct packed {
        logic [2:0]  lvl;
        logic [15:0] sr;
        logic [31:0] pc;
    } irq_ctx_t;

    // Status word: supervisor flag at bit 13, mask at bits 10:8
    function automatic logic [15:0] pack_sr(input logic s, input logic [2:0] m);
        return {2'b00, s, 2'b00, m, 8'h00};
    endfunction

    function automatic logic [31:0] vec_offset(input logic [7:0] v);
        return {22'd0, v, 2'b00};
    endfunction

endpackage

// File: rtl/irqa_level_filter.sv
module irqa_level_filter #(
    parameter int LVL_W    = 3,
    parameter int STABLE_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] raw_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             top_edge_o
);
    localparam logic [LVL_W-1:0] TOP = '1;

    logic [LVL_W-1:0] hist_q [STABLE_N];
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] prev_q;
    logic             agree;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STABLE_N; i++) hist_q[i] <= '0;
        end else begin
            hist_q[0] <= raw_i;
            for (int i = 1; i < STABLE_N; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    always_comb begin
        agree = 1'b1;
        for (int i = 1; i < STABLE_N; i++)
            if (hist_q[i] != hist_q[0]) agree = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            if (agree) lvl_q <= hist_q[0];
            prev_q <= lvl_q;
        end
    end

    assign lvl_o      = lvl_q;
    assign top_edge_o = (lvl_q == TOP) && (prev_q != TOP);

endmodule

// File: rtl/irqa_accept.sv
module irqa_accept (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] lvl_i,
    input  logic       top_edge_i,
    input  logic [2:0] mask_i,
    input  logic       ready_i,
    output logic       take_o,
    output logic [2:0] take_lvl_o
);
    logic pend_q;
    logic nmi_want;

    assign nmi_want = pend_q | top_edge_i;

    always_comb begin
        take_o     = 1'b0;
        take_lvl_o = lvl_i;
        if (ready_i) begin
            if (nmi_want) begin
                take_o     = 1'b1;
                take_lvl_o = 3'd7;
            end else if (lvl_i != 3'd0 && lvl_i != 3'd7 && lvl_i > mask_i) begin
                take_o     = 1'b1;
                take_lvl_o = lvl_i;
            end
        end
    end

    // Non-maskable entry is remembered until the sequencer is free
    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= nmi_want & ~ready_i;
    end

endmodule

// File: rtl/irqa_sequencer.sv
module irqa_sequencer
    import irqa_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [31:0] SP_RESET = 32'h0000_1000,
    parameter logic [31:0] PC_RESET = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [2:0]        take_lvl_i,
    input  logic              vbr_load_i,
    input  logic [31:0]       vbr_val_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [15:0]       mem_rdata_i,
    output logic [31:0]       pc_o,
    output logic [31:0]       sp_o,
    output logic [2:0]        mask_o,
    output logic              super_o,
    output logic              idle_o
);
    localparam int HI_W = ADDR_W - 4;

    seq_state_e        state_q;
    irq_ctx_t          ctx_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [15:0]       hi_q;
    logic [31:0]       pc_q, sp_q, vbr_q;
    logic [2:0]        mask_q;
    logic              super_q;
    logic [31:0]       vsum;
    logic [ADDR_W-1:0] push_addr;

    assign vsum      = vbr_q + vec_offset(mem_rdata_i[7:0]);
    assign push_addr = sp_q[ADDR_W-1:0] - ADDR_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            vaddr_q <= '0;
            hi_q    <= '0;
            pc_q    <= PC_RESET;
            sp_q    <= SP_RESET;
            vbr_q   <= '0;
            mask_q  <= '0;
            super_q <= 1'b0;
        end else begin
            if (vbr_load_i) vbr_q <= vbr_val_i;
            unique case (state_q)
                ST_IDLE: if (take_i) begin
                    ctx_q.lvl <= take_lvl_i;
                    ctx_q.sr  <= pack_sr(super_q, mask_q);
                    ctx_q.pc  <= pc_q;
                    super_q   <= 1'b1;
                    state_q   <= ST_IACK;
                end
                ST_IACK: if (mem_ack_i) begin
                    vaddr_q <= vsum[ADDR_W-1:0];
                    state_q <= ST_PUSH_PCL;
                end
                ST_PUSH_PCL: if (mem_ack_i) begin
                    sp_q    <= sp_q - 32'd2;
                    state_q <= ST_PUSH_PCH;
                end
                ST_PUSH_PCH: if (mem_ack_i) begin
                    sp_q    <= sp_q - 32'd2;
                    state_q <= ST_PUSH_SR;
                end
                ST_PUSH_SR: if (mem_ack_i) begin
                    sp_q    <= sp_q - 32'd2;
                    mask_q  <= ctx_q.lvl;
                    state_q <= ST_VEC_HI;
                end
                ST_VEC_HI: if (mem_ack_i) begin
                    hi_q    <= mem_rdata_i;
                    state_q <= ST_VEC_LO;
                end
                ST_VEC_LO: if (mem_ack_i) begin
                    pc_q    <= {hi_q, mem_rdata_i};
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = (state_q != ST_IDLE);
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_IACK:     mem_addr_o = {{HI_W{1'b1}}, ctx_q.lvl, 1'b0};
            ST_PUSH_PCL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = push_addr;
                mem_wdata_o = ctx_q.pc[15:0];
            end
            ST_PUSH_PCH: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = push_addr;
                mem_wdata_o = ctx_q.pc[31:16];
            end
            ST_PUSH_SR: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = push_addr;
                mem_wdata_o = ctx_q.sr;
            end
            ST_VEC_HI:   mem_addr_o = vaddr_q;
            ST_VEC_LO:   mem_addr_o = vaddr_q + ADDR_W'(2);
            default:     mem_addr_o = '0;
        endcase
    end

    assign pc_o    = pc_q;
    assign sp_o    = sp_q;
    assign mask_o  = mask_q;
    assign super_o = super_q;
    assign idle_o  = (state_q == ST_IDLE);

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
    parameter int          ADDR_W   = 24,
    parameter int          STABLE_N = 2,
    parameter logic [31:0] SP_RESET = 32'h0000_1000,
    parameter logic [31:0] PC_RESET = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ipl_i,
    input  logic              vbr_load_i,
    input  logic [31:0]       vbr_val_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [15:0]       mem_rdata_i,
    output logic [31:0]       pc_o,
    output logic [31:0]       sp_o,
    output logic [2:0]        mask_o,
    output logic              super_o,
    output logic              busy_o
);
    logic [2:0] flt_lvl;
    logic       top_edge;
    logic       take;
    logic [2:0] take_lvl;
    logic       idle;

    irqa_level_filter #(.LVL_W(3), .STABLE_N(STABLE_N)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .raw_i      (ipl_i),
        .lvl_o      (flt_lvl),
        .top_edge_o (top_edge)
    );

    irqa_accept u_accept (
        .clk        (clk),
        .rst        (rst),
        .lvl_i      (flt_lvl),
        .top_edge_i (top_edge),
        .mask_i     (mask_o),
        .ready_i    (idle),
        .take_o     (take),
        .take_lvl_o (take_lvl)
    );

    irqa_sequencer #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET), .PC_RESET(PC_RESET)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take),
        .take_lvl_i  (take_lvl),
        .vbr_load_i  (vbr_load_i),
        .vbr_val_i   (vbr_val_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .pc_o        (pc_o),
        .sp_o        (sp_o),
        .mask_o      (mask_o),
        .super_o     (super_o),
        .idle_o      (idle)
    );

    assign busy_o = ~idle;

endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              super_f,
    input logic [2:0]        mask,
    input logic [31:0]       sp,
    input logic              req,
    input logic              we,
    input logic              ack,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata
);
    assert_hold_req_R10: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && $stable(addr) && $stable(we) && $stable(wdata));

    assert_iack_first_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> req && !we && (addr[ADDR_W-1:4] == '1) && (addr[3:1] != 3'd0) && !addr[0]);

    assert_super_on_take_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> super_f);

    assert_mask_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
        mask >= $past(mask));

    assert_push_step_R7: assert property (@(posedge clk) disable iff (rst)
        req && we && ack |=> sp == $past(sp) - 32'd2);

    assert_sp_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !(req && we && ack) |=> $stable(sp));

endmodule

bind irq_accept_seq irqa_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_o),
    .super_f (super_o),
    .mask    (mask_o),
    .sp      (sp_o),
    .req     (mem_req_o),
    .we      (mem_we_o),
    .ack     (mem_ack_i),
    .addr    (mem_addr_o),
    .wdata   (mem_wdata_o)
);

// File: tb/irq_accept_seq_bench.sv
module irq_accept_seq_bench;
    localparam logic [31:0] SP_R = 32'h0000_1000;
    localparam logic [31:0] PC_R = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ipl = 3'd0;
    logic        vbr_load = 1'b0;
    logic [31:0] vbr_val = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic [31:0] pc, sp;
    logic [2:0]  mask;
    logic        sup, busy;

    irq_accept_seq #(.SP_RESET(SP_R), .PC_RESET(PC_R)) u_irq_accept_seq (
        .clk(clk), .rst(rst), .ipl_i(ipl), .vbr_load_i(vbr_load), .vbr_val_i(vbr_val),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .pc_o(pc), .sp_o(sp), .mask_o(mask), .super_o(sup), .busy_o(busy)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int iack_cnt = 0, nlog = 0, lat = 0;
    logic [23:0] last_iack = '0;
    logic [23:0] wa [8];
    logic [15:0] wd [8];
    bit          use_auto = 1'b1;
    logic [7:0]  cur_vec = 8'h40;

    // Reference model state
    logic [31:0] m_pc, m_sp, m_vbr;
    logic [2:0]  m_mask, prev_lvl;
    logic        m_s;

    function automatic logic [15:0] word_at(input logic [23:0] a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat > 0) lat--;
            else begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    if (nlog < 8) begin wa[nlog] = mem_addr; wd[nlog] = mem_wdata; end
                    nlog++;
                end else if (mem_addr[23:4] == 20'hFFFFF) begin
                    iack_cnt++;
                    last_iack = mem_addr;
                    mem_rdata = {8'hEE, use_auto ? 8'h18 + {5'd0, mem_addr[3:1]} : cur_vec};
                end else begin
                    mem_rdata = word_at(mem_addr);
                end
                lat = $urandom % 3;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ipl = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pc = PC_R; m_sp = SP_R; m_vbr = '0; m_mask = '0; m_s = 1'b0; prev_lvl = '0;
    endtask

    task automatic set_vbr(input logic [31:0] v);
        @(negedge clk);
        vbr_load = 1'b1; vbr_val = v;
        @(negedge clk);
        vbr_load = 1'b0;
        m_vbr = v;
    endtask

    // width 0: hold the level; 1: one-cycle pulse; 2+: pulse of that many cycles
    task automatic apply(input logic [2:0] lvl, input int width, input string tag);
        int          c0;
        bit          acc;
        logic [15:0] sr;
        logic [23:0] va;
        logic [31:0] hnd;
        c0 = iack_cnt; nlog = 0;
        if (width == 1) acc = 1'b0;
        else if (lvl == 3'd7) acc = (prev_lvl != 3'd7);
        else acc = (lvl != 3'd0) && (lvl > m_mask);
        @(negedge clk); ipl = lvl;
        if (width > 0) begin
            repeat (width) @(negedge clk);
            ipl = prev_lvl;
        end else prev_lvl = lvl;
        repeat (8) @(negedge clk);
        for (int g = 0; g < 300 && busy; g++) @(negedge clk);
        check(iack_cnt - c0 == (acc ? 1 : 0), tag, "acceptance count", iack_cnt - c0, acc ? 1 : 0);
        if (acc) begin
            sr = {2'b00, m_s, 2'b00, m_mask, 8'h00};
            va = 24'(m_vbr + {22'd0, (use_auto ? 8'h18 + {5'd0, lvl} : cur_vec), 2'b00});
            hnd = {word_at(va), word_at(va + 24'd2)};
            check(last_iack == (24'hFFFFF0 | {20'd0, lvl, 1'b0}), "R5", "ack address",
                  {8'd0, last_iack}, {8'd0, 24'hFFFFF0 | {20'd0, lvl, 1'b0}});
            check(nlog == 3, "R7", "write count", nlog, 3);
            check(wa[0] == 24'(m_sp - 2) && wd[0] == m_pc[15:0], "R7", "pc low push",
                  {wa[0][15:0], wd[0]}, {16'(m_sp - 2), m_pc[15:0]});
            check(wa[1] == 24'(m_sp - 4) && wd[1] == m_pc[31:16], "R7", "pc high push",
                  {wa[1][15:0], wd[1]}, {16'(m_sp - 4), m_pc[31:16]});
            check(wa[2] == 24'(m_sp - 6) && wd[2] == sr, "R7", "status push",
                  {wa[2][15:0], wd[2]}, {16'(m_sp - 6), sr});
            m_sp = m_sp - 6; m_mask = lvl; m_s = 1'b1; m_pc = hnd;
            check(pc == m_pc, "R9", "handler pc via R6 vector address", pc, m_pc);
        end else begin
            check(nlog == 0, tag, "no writes", nlog, 0);
        end
        check(sp == m_sp, "R7", "stack pointer", sp, m_sp);
        check(mask == m_mask, "R8", "mask", {29'd0, mask}, {29'd0, m_mask});
        check(sup == m_s, "R8", "supervisor", {31'd0, sup}, {31'd0, m_s});
        check(busy == 1'b0, "R9", "idle after sequence", {31'd0, busy}, 32'd0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        @(negedge clk);
        check(pc == PC_R, "R1", "reset pc", pc, PC_R);
        check(sp == SP_R, "R1", "reset sp", sp, SP_R);
        check(mask == 3'd0 && !sup, "R1", "reset mask/mode", {28'd0, sup, mask}, 32'd0);
        check(!mem_req && !busy, "R1", "reset bus idle", {30'd0, mem_req, busy}, 32'd0);

        use_auto = 1'b1;
        apply(3'd3, 0, "R3");           // above mask 0, vector base 0
        apply(3'd2, 0, "R3");           // below mask
        apply(3'd3, 0, "R3");           // equal to mask
        apply(3'd6, 1, "R2");           // one-cycle pulse ignored
        use_auto = 1'b0; cur_vec = 8'h80;
        apply(3'd5, 0, "R3");           // arbitrary vector byte
        use_auto = 1'b1;
        apply(3'd7, 0, "R4");           // non-maskable entry
        apply(3'd7, 0, "R4");           // held: no retrigger
        apply(3'd0, 0, "R4");
        apply(3'd7, 0, "R4");           // re-entry with mask already 7

        do_reset();
        set_vbr(32'h0001_2340);
        apply(3'd1, 0, "R6");           // relocated base
        apply(3'd4, 2, "R2");           // two-cycle pulse accepted
        apply(3'd4, 1, "R2");

        for (int it = 0; it < 70; it++) begin
            if ($urandom % 6 == 0) begin
                do_reset();
                if ($urandom % 2 == 0) set_vbr({12'd0, 16'($urandom), 4'd0});
            end
            use_auto = ($urandom % 2) == 0;
            cur_vec  = 8'h40 + 8'($urandom % 192);
            begin
                logic [2:0] l;
                l = 3'($urandom % 8);
                apply(l, ($urandom % 5 == 0 && l != prev_lvl) ? 1 : 0, "R3");
            end
        end
        finish_run();
    end

endmodule